// File: doc/BRIEF.md
# Pulse-Swallow Divider Controller

This block sequences a two-modulus prescaler so that a fast clock is divided by a programmable overall ratio. The prescaler divides the fast clock by N or by N+1, and the controller picks which one through a modulus-select line. A swallow counter keeps the prescaler at N+1 for a set number of prescaler cycles. A main counter sets how many prescaler cycles make up one output period. Both counters start together at the beginning of every output period.

The prescaler is modelled inside the block as a behavioural counter on the fast clock. Its output is a one-clock enable pulse rather than a derived clock, so all logic runs in the fast clock domain. One output period is A·(N+1) + (M−A)·N fast clocks long, where A is the swallow count and M is the main count. The controller emits a single one-clock pulse per period. The two counts come in on plain configuration pins and take effect only at a period boundary.

There is no streaming data path here. All pins are plain control and status signals, and none uses a valid/ready handshake.

Top module: `swallow_div_ctrl`

## Requirements
- R1: Each prescaler cycle lasts PRE_N+1 fast clocks while `mod_hi` is 1 and PRE_N fast clocks while it is 0. `presc_tick` is 1 for exactly the last fast clock of every prescaler cycle.
- R2: Within every output period, `mod_hi` is 1 for exactly the first A_eff prescaler cycles and 0 for all the cycles after them.
- R3: Every output period contains exactly M_eff prescaler cycles.
- R4: `div_out` is a one-clock pulse on the fast clock right after the final `presc_tick` of a period. Consecutive pulses are A_eff·(PRE_N+1) + (M_eff−A_eff)·PRE_N fast clocks apart.
- R5: If `cfg_swallow` exceeds M_eff, A_eff is set equal to M_eff, so the whole period runs at PRE_N+1.
- R6: A `cfg_main` value of 0 is treated as 1, so M_eff is always at least 1.
- R7: Both counts are sampled only at the clock edge that ends a period. A change on `cfg_swallow` or `cfg_main` at any other time leaves the period in progress unchanged in length.
- R8: While `rst_n` is 0, `div_out`, `mod_hi` and `presc_tick` are all 0. After release, the first `div_out` arrives PRE_N fast clocks later, because the first period is a single prescaler cycle at divide-by-PRE_N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_swallow | input | CNT_W | Swallow count A (number of prescaler cycles at PRE_N+1) |
| cfg_main | input | CNT_W | Main count M (prescaler cycles per output period) |
| mod_hi | output | 1 | Modulus select: 1 selects divide-by-PRE_N+1, 0 selects divide-by-PRE_N |
| presc_tick | output | 1 | Prescaler output pulse, high on the last fast clock of each prescaler cycle |
| div_out | output | 1 | Divided output, one fast clock wide per period |

## Verification
`presc_tick` is decoded combinationally, so it is high during the last fast clock of a prescaler cycle. `mod_hi` and the counters change on the rising edge that ends that fast clock, and `div_out` becomes visible in the following fast clock. The bench samples every output on the falling edge. It counts falling edges from one tick to the next, and from one `div_out` to the next, so each measured length lands on exactly the clock where the result is due. The bench also captures the configuration pins at each `div_out`, because that is what the design loaded on the edge just before. Configuration is changed only between falling edges, which makes the expected counts for the next period independent of process ordering.

// File: rtl/swc_pkg.sv
package swc_pkg;
  localparam int unsigned SWC_DEF_PRE_N = 4;
  localparam int unsigned SWC_DEF_CNT_W = 4;

  typedef enum logic {
    MOD_LO = 1'b0,
    MOD_HI = 1'b1
  } swc_mod_e;
endpackage

// File: rtl/swc_cfg_clamp.sv
module swc_cfg_clamp #(
  parameter int unsigned CNT_W = 4
) (
  input  logic [CNT_W-1:0] raw_a,
  input  logic [CNT_W-1:0] raw_m,
  output logic [CNT_W-1:0] eff_a,
  output logic [CNT_W-1:0] eff_m
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_comb begin
    eff_m = (raw_m == '0) ? ONE : raw_m;
    eff_a = (raw_a > eff_m) ? eff_m : raw_a;
  end
endmodule

// File: rtl/swc_prescaler.sv
module swc_prescaler
  import swc_pkg::*;
#(
  parameter int unsigned PRE_N = 4,
  parameter int unsigned PW    = 3
) (
  input  logic     clk,
  input  logic     rst_n,
  input  swc_mod_e modsel,
  output logic     tick
);
  localparam logic [PW-1:0] LAST_LO = PW'(PRE_N - 1);
  localparam logic [PW-1:0] LAST_HI = PW'(PRE_N);

  logic [PW-1:0] pcnt;
  logic [PW-1:0] last_idx;

  always_comb begin
    last_idx = (modsel == MOD_HI) ? LAST_HI : LAST_LO;
    tick     = (pcnt == last_idx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pcnt <= '0;
    else if (tick) pcnt <= '0;
    else           pcnt <= pcnt + 1'b1;
  end

  // R1
  pcnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt <= LAST_HI);

  // R1
  lo_mod_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (modsel == MOD_LO) |-> (pcnt <= LAST_LO));
endmodule

// File: rtl/swc_counters.sv
module swc_counters
  import swc_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] eff_a,
  input  logic [CNT_W-1:0] eff_m,
  output swc_mod_e         modsel,
  output logic             pulse
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] a_cnt;
  logic [CNT_W-1:0] m_cnt;
  logic             at_end;

  always_comb begin
    at_end = (m_cnt == ONE);
    modsel = (a_cnt != '0) ? MOD_HI : MOD_LO;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_cnt <= '0;
      m_cnt <= ONE;
      pulse <= 1'b0;
    end else begin
      pulse <= tick & at_end;
      if (tick) begin
        if (at_end) begin
          m_cnt <= eff_m;
          a_cnt <= eff_a;
        end else begin
          m_cnt <= m_cnt - 1'b1;
          if (a_cnt != '0) a_cnt <= a_cnt - 1'b1;
        end
      end
    end
  end

  // R5
  a_within_m_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a_cnt <= m_cnt);

  // R6
  m_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_cnt != '0);

  // R2
  mod_change_at_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(modsel) |-> $past(tick));

  // R4
  pulse_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> $past(tick));

  // R4
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);
endmodule

// File: rtl/swallow_div_ctrl.sv
module swallow_div_ctrl
  import swc_pkg::*;
#(
  parameter int unsigned PRE_N = SWC_DEF_PRE_N,
  parameter int unsigned CNT_W = SWC_DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cfg_swallow,
  input  logic [CNT_W-1:0] cfg_main,
  output logic             mod_hi,
  output logic             presc_tick,
  output logic             div_out
);
  localparam int unsigned PW = $clog2(PRE_N + 1);

  logic [CNT_W-1:0] eff_a;
  logic [CNT_W-1:0] eff_m;
  swc_mod_e         modsel;
  logic             tick;

  swc_cfg_clamp #(.CNT_W(CNT_W)) u_clamp (
    .raw_a (cfg_swallow),
    .raw_m (cfg_main),
    .eff_a (eff_a),
    .eff_m (eff_m)
  );

  swc_prescaler #(.PRE_N(PRE_N), .PW(PW)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .modsel (modsel),
    .tick   (tick)
  );

  swc_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .eff_a  (eff_a),
    .eff_m  (eff_m),
    .modsel (modsel),
    .pulse  (div_out)
  );

  assign mod_hi     = (modsel == MOD_HI);
  assign presc_tick = tick;

  // R8
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!div_out && !mod_hi));
endmodule

// File: tb/sim_swallow_div_ctrl.sv
module sim_swallow_div_ctrl;
  localparam int N  = 4;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] cfg_swallow = '0;
  logic [CW-1:0] cfg_main = CW'(1);
  logic          mod_hi, presc_tick, div_out;

  int tests = 0, fails = 0;
  int since = 0, tlen = 1, hi_cnt = 0, tk_cnt = 0;
  int a_act = 0, m_act = 1;
  bit started = 0, seen_lo = 0;
  string tag = "R4";

  always #4 clk = ~clk;

  swallow_div_ctrl #(.PRE_N(N), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_swallow(cfg_swallow), .cfg_main(cfg_main),
    .mod_hi(mod_hi), .presc_tick(presc_tick), .div_out(div_out)
  );

  function automatic int eff_m_of(int m);
    return (m == 0) ? 1 : m;
  endfunction

  function automatic int eff_a_of(int a, int m);
    return (a > eff_m_of(m)) ? eff_m_of(m) : a;
  endfunction

  task automatic chk(string t, int got, int exp, string what);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", t, what, got, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    since++;
    tlen++;
    if (presc_tick) begin
      chk("R1", tlen, mod_hi ? N + 1 : N, "prescaler cycle length");
      if (mod_hi) begin
        hi_cnt++;
        if (seen_lo) chk("R2", 1, 0, "high modulus after low in period");
      end else seen_lo = 1;
      tk_cnt++;
      tlen = 0;
    end
    if (div_out) begin
      if (started) begin
        chk(tag, since, a_act * (N + 1) + (m_act - a_act) * N, "period length");
        chk("R2", hi_cnt, a_act, "high-modulus cycles");
        chk("R3", tk_cnt, m_act, "prescaler cycles per period");
      end else begin
        chk("R8", since, N, "first pulse delay");
        started = 1;
      end
      since = 0; hi_cnt = 0; tk_cnt = 0; seen_lo = 0;
      a_act = eff_a_of(int'(cfg_swallow), int'(cfg_main));
      m_act = eff_m_of(int'(cfg_main));
    end
    if (since > 2000) begin
      fails++;
      tests++;
      $display("FAIL watchdog: got %0d expected below 2000 clocks", since);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  task automatic wait_pulses(int n);
    int seen = 0;
    while (seen < n) begin
      step();
      if (div_out) seen++;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R8", {29'd0, div_out, mod_hi, presc_tick}, 0, "outputs in reset");
    rst_n = 1'b1;
    wait_pulses(1);

    tag = "R4";
    for (int m = 1; m < (1 << CW); m++) begin
      for (int a = 0; a <= m; a++) begin
        cfg_main = CW'(m);
        cfg_swallow = CW'(a);
        wait_pulses(2);
      end
    end

    tag = "R5";
    for (int m = 1; m < 6; m++) begin
      cfg_main = CW'(m);
      cfg_swallow = CW'(m + 3);
      wait_pulses(2);
    end

    tag = "R6";
    cfg_main = '0;
    cfg_swallow = '0;
    wait_pulses(2);
    cfg_swallow = CW'(5);
    wait_pulses(2);

    tag = "R7";
    cfg_main = CW'(5);
    cfg_swallow = CW'(2);
    wait_pulses(2);
    repeat (7) step();
    cfg_main = CW'(11);
    cfg_swallow = CW'(7);
    wait_pulses(1);
    repeat (30) step();
    cfg_main = CW'(2);
    cfg_swallow = CW'(1);
    wait_pulses(3);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule